// File: doc/BRIEF.md
# Raster readout timing generator

This block paces the readout of a pixel array. It produces a frame-valid level, a line-valid level, a one-cycle pixel strobe, and the physical row and column coordinate of the pixel being emitted. The active window and the horizontal and vertical blanking lengths are parameters. A frame is a run of emitted lines followed by blank lines. Each line is a run of emitted pixel slots followed by blank slots. A decimating mode reads two of every eight rows or columns. An optional ring of extra pixels can surround the image, and those pixels can be presented either as image data or as blanking.

Readout is started by a chip-enable level or a restart pulse. After either, frame-valid stays low for a programmable number of line times before the first frame, standing in for the exposure delay. A low-power mode stretches every pixel slot to two clocks. The geometry controls are captured only when a frame or start delay begins. The line-valid presentation controls act at once. All controls are plain level inputs sampled on the clock. The outputs carry no handshake: the strobe marks each pixel, and a downstream stage must take it in that cycle. The parameters are expected to give active widths and heights that are multiples of the skip period, and blanking lengths of at least one.

Top module: `raster_timing_gen`

## Requirements
- R1: While `rst_n` is low or `soft_rst` is high, all outputs are low and both coordinates read zero. One cycle after release, with `chip_en` high, a start event occurs that is identical to R13.
- R2: When `chip_en` is sampled low, the next cycle shows frame-valid, line-valid and strobe low. When `chip_en` is sampled high again, a start event occurs.
- R3: After a start event, N = `start_delay` line times pass with frame-valid low, and then the frame begins at row slot 0. When N is 0, the frame begins directly.
- R4: A frame holds R emitted row slots followed by VBLANK blank lines. Each line holds C emitted column slots followed by HBLANK blank slots. Frame-valid is high on visible rows. The strobe pulses once per visible pixel slot.
- R5: Coordinates are physical: active pixel x sits at 4+x, the left or top ring at 0..3, and the right or bottom ring at ACT+4..ACT+7.
- R6: In skip mode, emitted active index k maps to array position (k/2)*8 + k%2, so ACT/4 positions are emitted per axis.
- R7: With the ring enabled, 4 slots are added on every side, giving 8 more rows and 8 more columns, in both skip and normal modes.
- R8: With the ring enabled, `border_show`=1 makes ring pixels visible and strobed, and `border_show`=0 makes them blanking. Without the ring, `border_show` has no effect.
- R9: In normal mode (both line-valid modes off), line-valid is high only on visible pixel slots of visible rows. It stays low through vertical blanking and the start delay.
- R10: With `lv_continuous`=1, line-valid is high on the visible column slots of every line, including blank lines and start-delay lines.
- R11: With `lv_xor`=1 and `lv_continuous`=0, line-valid equals the R10 signal XOR frame-valid. `lv_continuous` takes priority over `lv_xor`.
- R12: With low power captured, each slot lasts two clocks and the strobe pulses only in the second clock, so two strobes are never adjacent.
- R13: A `restart` pulse sampled while enabled abandons the current frame. It restarts the start delay from line slot 0 and captures the configuration afresh.
- R14: `border_en`, `border_show`, `row_skip4`, `col_skip4` and `low_power` are captured only at a start event or at the first slot of each frame. Changes mid-frame take effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| soft_rst | input | 1 | Synchronous return to power-up state |
| chip_en | input | 1 | Readout enable level |
| restart | input | 1 | Abandon frame and restart, one-cycle pulse |
| border_en | input | 1 | Add 4-pixel ring around the image |
| border_show | input | 1 | Ring shown as pixels (1) or blanking (0) |
| lv_continuous | input | 1 | Line-valid keeps its cadence in vertical blanking |
| lv_xor | input | 1 | Line-valid is continuous signal XOR frame-valid |
| row_skip4 | input | 1 | Read 2 of every 8 rows |
| col_skip4 | input | 1 | Read 2 of every 8 columns |
| low_power | input | 1 | Half pixel rate |
| start_delay | input | DLY_W | Line times of blank lead-in after a start event |
| frame_valid | output | 1 | High on visible rows |
| line_valid | output | 1 | Line-valid in the selected mode |
| pix_en | output | 1 | One-cycle strobe per emitted pixel |
| row_addr | output | clog2(ACT_ROWS+8) | Physical row of the current pixel |
| col_addr | output | clog2(ACT_COLS+8) | Physical column of the current pixel |

## Verification
A restart can fall in the same clock as the last slot of a frame, where the frame wrap would otherwise re-capture the configuration and begin row 0. The bench drives the pulse on exactly that cycle while also changing the geometry inputs. It then expects the start delay to run again, with the line length of the new configuration, and expects no frame to begin. A second coincidence places a geometry change in the middle of a frame. The old geometry must hold until the frame wraps, and the new one must apply from the next frame. Both cases are judged cycle by cycle against an arithmetic model of slot, line and coordinate.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

  typedef enum logic [1:0] {
    RTG_IDLE  = 2'd0,
    RTG_DELAY = 2'd1,
    RTG_FRAME = 2'd2
  } rtg_state_e;

  // Geometry and pacing settings captured at segment starts
  typedef struct packed {
    logic brd_en;
    logic brd_show;
    logic row_skip;
    logic col_skip;
    logic low_pwr;
  } rtg_cfg_t;

  localparam rtg_cfg_t RTG_CFG_RESET = '0;

  // Number of positions emitted per axis in decimating mode
  function automatic int skip_span(input int n_full, input int rd, input int per);
    return (n_full / per) * rd;
  endfunction

endpackage

// File: rtl/rtg_pace.sv
module rtg_pace (
  input  logic clk,
  input  logic rst_n,
  input  logic seg_clr,
  input  logic low_pwr,
  output logic tick
);

  logic phase_q;

  // phase is cleared at each segment start so a low-power slot always
  // spans an even/odd pair and the advance lands on the second clock
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
    end else if (seg_clr) begin
      phase_q <= 1'b0;
    end else if (low_pwr) begin
      phase_q <= ~phase_q;
    end else begin
      phase_q <= 1'b0;
    end
  end

  assign tick = !low_pwr || phase_q;

endmodule

// File: rtl/rtg_axis_map.sv
module rtg_axis_map
  import rtg_pkg::*;
#(
  parameter int N_ACT  = 640,
  parameter int BORDER = 4,
  parameter int RD     = 2,
  parameter int PER    = 8,
  parameter int SW     = 10,
  parameter int AW     = 10
) (
  input  logic [SW-1:0] slot,
  input  logic          brd_en,
  input  logic          brd_show,
  input  logic          skip,
  output logic [SW-1:0] n_out,
  output logic          visible,
  output logic [AW-1:0] phys
);

  localparam int  N_SKIP = skip_span(N_ACT, RD, PER);
  localparam bit  POW2   = ((RD & (RD - 1)) == 0) && ((PER & (PER - 1)) == 0);

  logic [SW-1:0] n_act;
  logic [SW-1:0] lo_edge;
  logic [SW-1:0] k_idx;
  logic [SW-1:0] skip_pos;
  logic [SW-1:0] act_pos;
  logic          in_span;
  logic          in_left;
  logic          in_right;

  always_comb begin
    n_act   = skip ? SW'(N_SKIP) : SW'(N_ACT);
    n_out   = n_act + (brd_en ? SW'(2 * BORDER) : '0);
    lo_edge = brd_en ? SW'(BORDER) : '0;
    in_span = slot < n_out;
    in_left = brd_en && (slot < SW'(BORDER));
    in_right = brd_en && in_span && (slot >= n_act + SW'(BORDER));
    k_idx   = slot - lo_edge;
  end

  // decimation address: shift/mask when both factors are powers of two
  generate
    if (POW2) begin : g_shift
      localparam int RD_SH  = $clog2(RD);
      localparam int PER_SH = $clog2(PER);
      assign skip_pos = ((k_idx >> RD_SH) << PER_SH) | (k_idx & SW'(RD - 1));
    end else begin : g_div
      assign skip_pos = (k_idx / SW'(RD)) * SW'(PER) + (k_idx % SW'(RD));
    end
  endgenerate

  always_comb begin
    act_pos = skip ? skip_pos : k_idx;
    visible = in_span && (!(in_left || in_right) || brd_show);
    if (in_left) begin
      phys = AW'(slot);
    end else if (in_right) begin
      phys = AW'(slot - n_act + SW'(N_ACT));
    end else begin
      phys = AW'(act_pos + SW'(BORDER));
    end
  end

endmodule

// File: rtl/rtg_sequencer.sv
module rtg_sequencer
  import rtg_pkg::*;
#(
  parameter int HW     = 10,
  parameter int VW     = 10,
  parameter int DW     = 8,
  parameter int HBLANK = 32,
  parameter int VBLANK = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          chip_en,
  input  logic          restart,
  input  logic [DW-1:0] start_dly,
  input  rtg_cfg_t      cfg_in,
  input  logic          tick,
  input  logic [HW-1:0] cols_out,
  input  logic [VW-1:0] rows_out,
  output rtg_state_e    state,
  output logic [HW-1:0] h_cnt,
  output logic [VW-1:0] v_cnt,
  output rtg_cfg_t      cfg_q,
  output logic          seg_begin
);

  logic [DW-1:0] dly_q;
  logic [HW-1:0] line_last;
  logic [VW-1:0] frame_last;
  logic          stop;
  logic          start_evt;
  logic          line_end;
  logic          frame_end;
  logic          enter_frame;

  always_comb begin
    line_last   = cols_out + HW'(HBLANK - 1);
    frame_last  = rows_out + VW'(VBLANK - 1);
    stop        = soft_rst || !chip_en;
    start_evt   = !stop && ((state == RTG_IDLE) || restart);
    line_end    = (h_cnt == line_last);
    frame_end   = (v_cnt == frame_last);
    enter_frame = !stop && !start_evt && tick && line_end &&
                  (((state == RTG_DELAY) && (dly_q <= DW'(1))) ||
                   ((state == RTG_FRAME) && frame_end));
    seg_begin   = stop || start_evt || enter_frame;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || stop) begin
      state <= RTG_IDLE;
      h_cnt <= '0;
      v_cnt <= '0;
      dly_q <= '0;
      cfg_q <= RTG_CFG_RESET;
    end else if (start_evt) begin
      state <= (start_dly == '0) ? RTG_FRAME : RTG_DELAY;
      h_cnt <= '0;
      v_cnt <= '0;
      dly_q <= start_dly;
      cfg_q <= cfg_in;
    end else if (tick) begin
      if (line_end) begin
        h_cnt <= '0;
        if (state == RTG_DELAY) begin
          if (dly_q <= DW'(1)) begin
            state <= RTG_FRAME;
            v_cnt <= '0;
            cfg_q <= cfg_in;
          end else begin
            dly_q <= dly_q - DW'(1);
          end
        end else if (frame_end) begin
          v_cnt <= '0;
          cfg_q <= cfg_in;
        end else begin
          v_cnt <= v_cnt + VW'(1);
        end
      end else begin
        h_cnt <= h_cnt + HW'(1);
      end
    end
  end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int ACT_COLS    = 640,
  parameter int ACT_ROWS    = 480,
  parameter int BORDER      = 4,
  parameter int SKIP_READ   = 2,
  parameter int SKIP_PERIOD = 8,
  parameter int HBLANK      = 32,
  parameter int VBLANK      = 8,
  parameter int DLY_W       = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  soft_rst,
  input  logic                                  chip_en,
  input  logic                                  restart,
  input  logic                                  border_en,
  input  logic                                  border_show,
  input  logic                                  lv_continuous,
  input  logic                                  lv_xor,
  input  logic                                  row_skip4,
  input  logic                                  col_skip4,
  input  logic                                  low_power,
  input  logic [DLY_W-1:0]                      start_delay,
  output logic                                  frame_valid,
  output logic                                  line_valid,
  output logic                                  pix_en,
  output logic [$clog2(ACT_ROWS+2*BORDER)-1:0]  row_addr,
  output logic [$clog2(ACT_COLS+2*BORDER)-1:0]  col_addr
);

  localparam int COL_SPAN = ACT_COLS + 2 * BORDER;
  localparam int ROW_SPAN = ACT_ROWS + 2 * BORDER;
  localparam int HW       = $clog2(COL_SPAN + HBLANK + 1);
  localparam int VW       = $clog2(ROW_SPAN + VBLANK + 1);
  localparam int CAW      = $clog2(COL_SPAN);
  localparam int RAW      = $clog2(ROW_SPAN);

  rtg_cfg_t      cfg_in;
  rtg_cfg_t      cfg_q;
  rtg_state_e    state;
  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic [HW-1:0] cols_out;
  logic [VW-1:0] rows_out;
  logic          seg_begin;
  logic          tick;
  logic          col_vis;
  logic          row_vis;
  logic [CAW-1:0] col_phys;
  logic [RAW-1:0] row_phys;
  logic          running;
  logic          lv_cont;
  logic          lv_norm;
  logic          cfg_lp;

  assign cfg_in = '{brd_en:   border_en,
                    brd_show: border_show,
                    row_skip: row_skip4,
                    col_skip: col_skip4,
                    low_pwr:  low_power};

  rtg_sequencer #(
    .HW(HW), .VW(VW), .DW(DLY_W), .HBLANK(HBLANK), .VBLANK(VBLANK)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .chip_en   (chip_en),
    .restart   (restart),
    .start_dly (start_delay),
    .cfg_in    (cfg_in),
    .tick      (tick),
    .cols_out  (cols_out),
    .rows_out  (rows_out),
    .state     (state),
    .h_cnt     (h_cnt),
    .v_cnt     (v_cnt),
    .cfg_q     (cfg_q),
    .seg_begin (seg_begin)
  );

  rtg_pace u_pace (
    .clk     (clk),
    .rst_n   (rst_n),
    .seg_clr (seg_begin),
    .low_pwr (cfg_q.low_pwr),
    .tick    (tick)
  );

  rtg_axis_map #(
    .N_ACT(ACT_COLS), .BORDER(BORDER), .RD(SKIP_READ), .PER(SKIP_PERIOD),
    .SW(HW), .AW(CAW)
  ) u_col_map (
    .slot     (h_cnt),
    .brd_en   (cfg_q.brd_en),
    .brd_show (cfg_q.brd_show),
    .skip     (cfg_q.col_skip),
    .n_out    (cols_out),
    .visible  (col_vis),
    .phys     (col_phys)
  );

  rtg_axis_map #(
    .N_ACT(ACT_ROWS), .BORDER(BORDER), .RD(SKIP_READ), .PER(SKIP_PERIOD),
    .SW(VW), .AW(RAW)
  ) u_row_map (
    .slot     (v_cnt),
    .brd_en   (cfg_q.brd_en),
    .brd_show (cfg_q.brd_show),
    .skip     (cfg_q.row_skip),
    .n_out    (rows_out),
    .visible  (row_vis),
    .phys     (row_phys)
  );

  always_comb begin
    running     = (state != RTG_IDLE);
    frame_valid = (state == RTG_FRAME) && row_vis;
    lv_cont     = running && col_vis;
    lv_norm     = frame_valid && col_vis;
    if (lv_continuous) begin
      line_valid = lv_cont;
    end else if (lv_xor) begin
      line_valid = lv_cont ^ frame_valid;
    end else begin
      line_valid = lv_norm;
    end
    pix_en   = tick && lv_norm;
    row_addr = running ? row_phys : '0;
    col_addr = running ? col_phys : '0;
    cfg_lp   = cfg_q.low_pwr;
  end

endmodule

// File: rtl/rtg_checker.sv
module rtg_checker #(
  parameter int DLY_W = 8,
  parameter int RAW   = 9,
  parameter int CAW   = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             chip_en,
  input logic             restart,
  input logic             lv_continuous,
  input logic             lv_xor,
  input logic [DLY_W-1:0] start_delay,
  input logic             frame_valid,
  input logic             line_valid,
  input logic             pix_en,
  input logic [RAW-1:0]   row_addr,
  input logic [CAW-1:0]   col_addr,
  input logic             cfg_lp
);

  // R1: soft reset silences everything on the following cycle
  a_r1_soft_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!frame_valid && !line_valid && !pix_en &&
                  row_addr == '0 && col_addr == '0));

  // R2: dropping enable stops readout on the following cycle
  a_r2_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> (!frame_valid && !line_valid && !pix_en));

  // R13: a restart with a nonzero lead-in blanks the frame next cycle
  a_r13_restart_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && chip_en && !soft_rst && start_delay != '0) |=> !frame_valid);

  // R12: in low power two strobes are never adjacent
  a_r12_lp_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_lp && pix_en) |=> !pix_en);

  // R4: a pixel strobe only occurs inside a visible row
  a_r4_pix_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |-> frame_valid);

  // R9: normal line-valid is low outside visible rows
  a_r9_normal_lv: assert property (@(posedge clk) disable iff (!rst_n)
    (!lv_continuous && !lv_xor && !frame_valid) |-> !line_valid);

endmodule

bind raster_timing_gen rtg_checker #(
  .DLY_W(DLY_W), .RAW(RAW), .CAW(CAW)
) u_rtg_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .soft_rst      (soft_rst),
  .chip_en       (chip_en),
  .restart       (restart),
  .lv_continuous (lv_continuous),
  .lv_xor        (lv_xor),
  .start_delay   (start_delay),
  .frame_valid   (frame_valid),
  .line_valid    (line_valid),
  .pix_en        (pix_en),
  .row_addr      (row_addr),
  .col_addr      (col_addr),
  .cfg_lp        (cfg_lp)
);

// File: tb/tb_raster_timing_gen.sv
module tb_raster_timing_gen;

  localparam int AC = 16;
  localparam int AR = 16;
  localparam int HB = 3;
  localparam int VB = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0, soft_rst = 1'b0, chip_en = 1'b0, restart = 1'b0;
  logic border_en = 1'b0, border_show = 1'b0, lv_continuous = 1'b0, lv_xor = 1'b0;
  logic row_skip4 = 1'b0, col_skip4 = 1'b0, low_power = 1'b0;
  logic [7:0] start_delay = 8'd2;
  logic frame_valid, line_valid, pix_en;
  logic [4:0] row_addr, col_addr;

  raster_timing_gen #(
    .ACT_COLS(AC), .ACT_ROWS(AR), .BORDER(4), .SKIP_READ(2), .SKIP_PERIOD(8),
    .HBLANK(HB), .VBLANK(VB), .DLY_W(8)
  ) dut (.*);

  always #10 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  string ctx = "R1 reset";

  // model: 0 idle, 1 lead-in, 2 frame; m_cnt counts clocks in segment
  int m_st = 0, m_cnt = 0, m_dly = 0;
  bit [4:0] m_cfg = '0; // [4]ring [3]show [2]row skip [1]col skip [0]low power

  function automatic int n_act(input int full, input bit skip);
    return skip ? (full / 8) * 2 : full;
  endfunction

  function automatic int n_out(input int full, input bit en, input bit skip);
    return n_act(full, skip) + (en ? 8 : 0);
  endfunction

  function automatic bit [4:0] cur_cfg();
    return {border_en, border_show, row_skip4, col_skip4, low_power};
  endfunction

  task automatic axis(input int full, input int slot, input bit en, input bit show,
                      input bit skip, output bit vis, output int phys);
    int na, k;
    na = n_act(full, skip);
    vis = 1'b0;
    phys = 0;
    if (slot < na + (en ? 8 : 0)) begin
      if (en && slot < 4) begin
        vis = show; phys = slot;
      end else if (en && slot >= 4 + na) begin
        vis = show; phys = full + 4 + (slot - 4 - na);
      end else begin
        k = en ? slot - 4 : slot;
        vis = 1'b1;
        phys = 4 + (skip ? (k / 2) * 8 + (k % 2) : k);
      end
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s [%s] cycle %0d: actual %0d expected %0d", tag, ctx, cyc, act, exp);
    end
  endtask

  task automatic model_edge();
    int div, ll, seg;
    if (!rst_n || soft_rst || !chip_en) begin
      m_st = 0;
    end else if (m_st == 0 || restart) begin
      m_cfg = cur_cfg(); m_cnt = 0; m_dly = start_delay;
      m_st = (start_delay == 0) ? 2 : 1;
    end else begin
      m_cnt++;
      div = m_cfg[0] ? 2 : 1;
      ll = n_out(AC, m_cfg[4], m_cfg[1]) + HB;
      seg = (m_st == 1) ? m_dly * ll : (n_out(AR, m_cfg[4], m_cfg[2]) + VB) * ll;
      if (m_cnt == seg * div) begin
        m_st = 2; m_cnt = 0; m_cfg = cur_cfg();
      end
    end
  endtask

  task automatic compare();
    int div, slot, ll, h, line, cp, rp;
    bit tick, cv, rv, efv, elv, epe, cont;
    string fvtag, lvtag;
    efv = 0; cont = 0; cv = 0; tick = 0; cp = 0; rp = 0; slot = 0;
    if (m_st != 0) begin
      div = m_cfg[0] ? 2 : 1;
      slot = m_cnt / div;
      tick = (div == 1) || (m_cnt % 2 == 1);
      ll = n_out(AC, m_cfg[4], m_cfg[1]) + HB;
      h = slot % ll;
      line = slot / ll;
      axis(AC, h, m_cfg[4], m_cfg[3], m_cfg[1], cv, cp);
      if (m_st == 2) begin
        axis(AR, line, m_cfg[4], m_cfg[3], m_cfg[2], rv, rp);
        efv = rv;
      end
      cont = cv;
    end
    if (lv_continuous) begin elv = cont; lvtag = "R10"; end
    else if (lv_xor) begin elv = cont ^ efv; lvtag = "R11"; end
    else begin elv = efv & cv; lvtag = "R9"; end
    epe = tick & efv & cv;
    if (m_st == 1) fvtag = "R3";
    else if (m_cfg[4]) fvtag = m_cfg[3] ? "R7" : "R8";
    else fvtag = "R4";
    chk(fvtag, frame_valid, efv);
    chk(lvtag, line_valid, elv);
    chk(m_cfg[0] ? "R12" : "R4", pix_en, epe);
    if (m_st == 0) begin
      chk("R1", row_addr, 0);
      chk("R1", col_addr, 0);
    end else if (epe) begin
      chk(m_cfg[2] ? "R6" : "R5", row_addr, rp);
      chk(m_cfg[1] ? "R6" : "R5", col_addr, cp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) begin
      @(negedge clk);
      cyc++;
      model_edge();
      compare();
    end
  endtask

  function automatic int line_clks();
    return (low_power ? 2 : 1) * (n_out(AC, border_en, col_skip4) + HB);
  endfunction

  function automatic int lead_and_frame();
    return line_clks() * (start_delay + n_out(AR, border_en, row_skip4) + VB);
  endfunction

  task automatic pulse_restart();
    restart = 1'b1;
    run(1);
    restart = 1'b0;
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL R4 [watchdog] actual timeout expected completion");
    finish_up();
  end

  initial begin
    int t;
    chip_en = 1'b1;
    // R1: outputs quiet under reset, then start after release
    run(3);
    rst_n = 1'b1;
    ctx = "R1 release";
    run(lead_and_frame() + 20);

    // R4 R5 R6 R7 R8 R9 R10 R11 R12: sweep every geometry with rotating line-valid modes
    for (int i = 0; i < 32; i++) begin
      int lvm;
      lvm = (i + i / 4) % 4;
      {border_en, border_show, row_skip4, col_skip4, low_power} = 5'(i);
      {lv_continuous, lv_xor} = 2'(lvm);
      ctx = $sformatf("sweep cfg %0d lv %0d", i, lvm);
      pulse_restart();
      run(lead_and_frame() + 3 * line_clks());
    end
    {lv_continuous, lv_xor} = 2'b00;

    // R14: geometry changed mid-frame must wait for the frame wrap
    ctx = "R14 mid-frame change";
    {border_en, border_show, row_skip4, col_skip4, low_power} = 5'b11000;
    pulse_restart();
    run(line_clks() * (start_delay + 5));
    {border_en, row_skip4, col_skip4} = 3'b011;
    run(900);

    // R13: restart in the middle of a low-power frame
    ctx = "R13 mid-frame restart";
    {border_en, border_show, row_skip4, col_skip4, low_power} = 5'b10001;
    lv_xor = 1'b1;
    pulse_restart();
    run(301);
    pulse_restart();
    run(lead_and_frame());
    lv_xor = 1'b0;

    // R13 R14: restart on the very edge where the frame would wrap, with new geometry
    ctx = "R13 restart at wrap";
    {border_en, border_show, row_skip4, col_skip4, low_power} = 5'b00000;
    start_delay = 8'd1;
    pulse_restart();
    t = lead_and_frame();
    run(t - 1);
    {border_en, border_show} = 2'b11;
    lv_continuous = 1'b1;
    pulse_restart();
    run(lead_and_frame() + line_clks());
    lv_continuous = 1'b0;

    // R2: enable drop mid-frame, then resume from a new lead-in
    ctx = "R2 enable";
    run(150);
    chip_en = 1'b0;
    run(6);
    chip_en = 1'b1;
    run(lead_and_frame() + 5);

    // R1: soft reset mid-frame
    ctx = "R1 soft reset";
    run(200);
    soft_rst = 1'b1;
    run(4);
    soft_rst = 1'b0;
    run(lead_and_frame() + 5);

    // R3: zero and longer lead-in
    ctx = "R3 zero delay";
    start_delay = 8'd0;
    pulse_restart();
    run(lead_and_frame() + line_clks());
    ctx = "R3 long delay";
    start_delay = 8'd5;
    row_skip4 = 1'b1;
    pulse_restart();
    run(lead_and_frame() + line_clks());

    finish_up();
  end

endmodule